// File: doc/BRIEF.md
# Sliced Wide-Word CIC Decimator

This block is an eight-stage cascaded integrator-comb decimator for the second decimation step of a multi-channel readout chain. Its input is a stream of samples that an earlier stage has already reduced by 128. It emits one scaled output for every R accepted inputs. R is chosen at run time from six powers of two between 16 and 512.

All internal arithmetic runs on a 112-bit word. That word is wide enough for the full bit growth at the largest ratio. To keep each adder small, every 112-bit add or subtract is split into eight 14-bit slices, worked least significant slice first, one slice per clock. The carry or borrow of each slice is held in a register and fed into the next slice. Each accepted sample therefore occupies the datapath for eight cycles. A sample that arrives earlier than that is rejected and flagged.

A change of ratio wipes all filter state, so the next output is built only from samples taken after the change.

Top module: `cic_sliced_decim`

## Requirements
- R1: After reset, out_valid and in_error are low and out_data is zero.
- R2: rate_sel codes 0 to 5 select R = 16·2^code. Codes 6 and 7 act as code 5 (R = 512). Exactly one output is produced per R accepted inputs, on the R-th input.
- R3: Each output equals bits [8L+17 : 8L−6] of the exact eight-stage CIC result, where L = log2(R). The CIC uses unit differential delay, sign-extended input and two's-complement arithmetic modulo 2^112.
- R4: After at least 8·(R−1)+1 equal inputs x, the output is exactly 64·x. This holds at both full-scale extremes: 131071 gives 8388544, and −131072 gives −8388608.
- R5: out_valid is a single-cycle pulse. It is registered by the eighth clock edge after the edge that accepts the R-th input.
- R6: An input is accepted when the datapath is idle, or in the cycle that processes the last slice. Inputs spaced eight cycles apart are therefore all accepted without error.
- R7: An in_valid that arrives while a sample is mid-way through its slices is dropped and has no effect on later outputs. in_error is high for exactly the cycle after it.
- R8: When the effective rate code changes, all integrator and comb state is cleared and the ratio counter restarts. Any sample in flight is discarded without producing an output. An input offered in the cycle of the change is ignored.
- R9: out_data holds its value between out_valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Decimation ratio code |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 18 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed scaled output sample |
| in_error | output | 1 | Input arrived while busy, dropped |

## Verification
A carry or borrow lost between slices, or a wrong slice index, corrupts the integrator sums in their upper bits. The damage reaches out_data at the very next output: within R inputs, or 16 inputs at the smallest ratio. A wrong scaling shift or a wrong ratio shows up on the first output after a rate change. It appears as a value off by a power of two, or as a pulse that is missing or comes too early. State that survives a flush when it should have been cleared is caught by the first output after the change, which then differs from a freshly started reference.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Map an out-of-range ratio code onto the largest legal one.
    function automatic logic [2:0] clamp_code(input logic [2:0] code, input logic [2:0] top);
        return (code > top) ? top : code;
    endfunction

endpackage

// File: rtl/cic_slice_addsub.sv
module cic_slice_addsub #(
    parameter int SLICE_W = 14
) (
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               cin,
    input  logic               sub,
    output logic [SLICE_W-1:0] sum,
    output logic               cout
);
    // Subtraction is a + ~b + carry; carry-in of 1 on the lowest slice.
    logic [SLICE_W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{SLICE_W{1'b0}}, cin};
    end
endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
    parameter int WORD_W   = 112,
    parameter int OUT_W    = 24,
    parameter int IN_W     = 18,
    parameter int N_STAGES = 8,
    parameter int MIN_LOG  = 4,
    parameter int CODE_W   = 3
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  scaled
);
    // Window the top OUT_W bits of the grown word: shift = N*log2(R) + IN_W - OUT_W.
    int shamt;

    always_comb begin
        shamt  = N_STAGES * (MIN_LOG + int'(code)) + IN_W - OUT_W;
        scaled = word[shamt +: OUT_W];
    end
endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl
    import cic_pkg::*;
#(
    parameter int N_SLICES = 8,
    parameter int MIN_LOG  = 4,
    parameter int N_CODES  = 6,
    parameter int CODE_W   = 3,
    parameter int SEL_W    = 3,
    parameter int CNT_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] rate_sel,
    output logic              load,
    output logic              active,
    output logic              dump,
    output logic              emit,
    output logic              flush,
    output logic [SEL_W-1:0]  slice_idx,
    output logic [CODE_W-1:0] rate_code,
    output logic [CODE_W-1:0] rate_eff,
    output logic [CNT_W-1:0]  dec_cnt,
    output logic              in_error
);
    typedef struct packed {
        logic              busy;
        logic [SEL_W-1:0]  slice;
        logic [CNT_W-1:0]  cnt;
        logic              dump;
        logic [CODE_W-1:0] rate;
        logic              err;
    } ctrl_t;

    localparam logic [SEL_W-1:0] LAST_SLICE = SEL_W'(N_SLICES - 1);

    ctrl_t st_d, st_q;
    logic  last;
    logic  can_accept;
    logic [CNT_W:0]   ratio;
    logic [CNT_W-1:0] ratio_m1;
    int unsigned      shamt;

    always_comb begin
        rate_eff   = CODE_W'(clamp_code(3'(rate_sel), 3'(N_CODES - 1)));
        flush      = (rate_eff != st_q.rate);
        shamt      = MIN_LOG + 32'(st_q.rate);
        ratio      = (CNT_W+1)'(1) << shamt;
        ratio_m1   = CNT_W'(ratio - (CNT_W+1)'(1));
        last       = st_q.busy && (st_q.slice == LAST_SLICE);
        can_accept = !st_q.busy || last;
        load       = in_valid && can_accept && !flush;

        st_d     = st_q;
        st_d.err = in_valid && !can_accept && !flush;

        if (flush) begin
            st_d.busy  = 1'b0;
            st_d.slice = '0;
            st_d.cnt   = '0;
            st_d.dump  = 1'b0;
            st_d.rate  = rate_eff;
        end else begin
            if (st_q.busy) begin
                st_d.slice = st_q.slice + SEL_W'(1);
                if (last) begin
                    st_d.busy = 1'b0;
                end
            end
            if (load) begin
                st_d.busy  = 1'b1;
                st_d.slice = '0;
                st_d.dump  = (st_q.cnt == ratio_m1);
                st_d.cnt   = (st_q.cnt == ratio_m1) ? '0 : st_q.cnt + CNT_W'(1);
            end
        end

        active    = st_q.busy && !flush;
        dump      = st_q.dump;
        emit      = last && st_q.dump && !flush;
        slice_idx = st_q.slice;
        rate_code = st_q.rate;
        dec_cnt   = st_q.cnt;
        in_error  = st_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cic_sliced_decim.sv
module cic_sliced_decim #(
    parameter int IN_W     = 18,
    parameter int OUT_W    = 24,
    parameter int N_STAGES = 8,
    parameter int SLICE_W  = 14,
    parameter int N_SLICES = 8,
    parameter int MIN_LOG  = 4,
    parameter int N_CODES  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(N_CODES)-1:0]   rate_sel,
    input  logic                         in_valid,
    input  logic [IN_W-1:0]              in_data,
    output logic                         out_valid,
    output logic [OUT_W-1:0]             out_data,
    output logic                         in_error
);
    localparam int WORD_W = SLICE_W * N_SLICES;
    localparam int RES_W  = WORD_W - SLICE_W;
    localparam int SEL_W  = $clog2(N_SLICES);
    localparam int BASE_W = $clog2(WORD_W);
    localparam int CODE_W = $clog2(N_CODES);
    localparam int CNT_W  = MIN_LOG + N_CODES - 1;
    localparam logic [SEL_W-1:0] LAST_SLICE = SEL_W'(N_SLICES - 1);

    typedef struct packed {
        logic [WORD_W-1:0]                x;
        logic [N_STAGES-1:0][WORD_W-1:0]  integ;
        logic [N_STAGES-1:0][WORD_W-1:0]  dly;
        logic [N_STAGES-1:0]              icarry;
        logic [N_STAGES-1:0]              ccarry;
        logic [RES_W-1:0]                 res;
        logic                             out_valid;
        logic [OUT_W-1:0]                 out_data;
    } dp_t;

    dp_t st_d, st_q;

    logic              load, active, dump, emit, flush;
    logic [SEL_W-1:0]  slice_idx;
    logic [CODE_W-1:0] rate_code, rate_eff;
    logic [CNT_W-1:0]  dec_cnt;
    logic [BASE_W-1:0] base;
    logic [SLICE_W-1:0] x_sl;

    // Per-stage slice results gathered into flat vectors.
    logic [N_STAGES*SLICE_W-1:0] isum_v;
    logic [N_STAGES*SLICE_W-1:0] csrc_v;
    logic [N_STAGES-1:0]         icout_v;
    logic [N_STAGES-1:0]         ccout_v;
    logic [SLICE_W-1:0]          comb_last;
    logic [WORD_W-1:0]           res_full;
    logic [OUT_W-1:0]            scaled;

    cic_ctrl #(
        .N_SLICES (N_SLICES),
        .MIN_LOG  (MIN_LOG),
        .N_CODES  (N_CODES),
        .CODE_W   (CODE_W),
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .rate_sel  (rate_sel),
        .load      (load),
        .active    (active),
        .dump      (dump),
        .emit      (emit),
        .flush     (flush),
        .slice_idx (slice_idx),
        .rate_code (rate_code),
        .rate_eff  (rate_eff),
        .dec_cnt   (dec_cnt),
        .in_error  (in_error)
    );

    assign base = BASE_W'(slice_idx) * BASE_W'(SLICE_W);
    assign x_sl = st_q.x[base +: SLICE_W];

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        logic [SLICE_W-1:0] i_b;
        logic [SLICE_W-1:0] i_sum;
        logic               i_co;
        logic               i_ci;
        logic [SLICE_W-1:0] c_a;
        logic [SLICE_W-1:0] c_sum;
        logic               c_co;
        logic               c_ci;

        if (s == 0) begin : g_head
            assign i_b = x_sl;
            assign c_a = g_stage[N_STAGES-1].i_sum;
        end else begin : g_body
            assign i_b = g_stage[s-1].i_sum;
            assign c_a = g_stage[s-1].c_sum;
        end

        assign i_ci = (slice_idx == '0) ? 1'b0 : st_q.icarry[s];
        assign c_ci = (slice_idx == '0) ? 1'b1 : st_q.ccarry[s];

        cic_slice_addsub #(.SLICE_W(SLICE_W)) u_integ (
            .a    (st_q.integ[s][base +: SLICE_W]),
            .b    (i_b),
            .cin  (i_ci),
            .sub  (1'b0),
            .sum  (i_sum),
            .cout (i_co)
        );

        cic_slice_addsub #(.SLICE_W(SLICE_W)) u_comb (
            .a    (c_a),
            .b    (st_q.dly[s][base +: SLICE_W]),
            .cin  (c_ci),
            .sub  (1'b1),
            .sum  (c_sum),
            .cout (c_co)
        );

        assign isum_v[s*SLICE_W +: SLICE_W] = i_sum;
        assign csrc_v[s*SLICE_W +: SLICE_W] = c_a;
        assign icout_v[s] = i_co;
        assign ccout_v[s] = c_co;
    end

    assign comb_last = g_stage[N_STAGES-1].c_sum;
    assign res_full  = {comb_last, st_q.res};

    cic_scale #(
        .WORD_W   (WORD_W),
        .OUT_W    (OUT_W),
        .IN_W     (IN_W),
        .N_STAGES (N_STAGES),
        .MIN_LOG  (MIN_LOG),
        .CODE_W   (CODE_W)
    ) u_scale (
        .word   (res_full),
        .code   (rate_code),
        .scaled (scaled)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;

        if (flush) begin
            st_d.integ  = '0;
            st_d.dly    = '0;
            st_d.icarry = '0;
            st_d.ccarry = '0;
            st_d.res    = '0;
        end else begin
            if (load) begin
                st_d.x = {{(WORD_W-IN_W){in_data[IN_W-1]}}, in_data};
            end
            if (active) begin
                for (int s = 0; s < N_STAGES; s++) begin
                    st_d.integ[s][base +: SLICE_W] = isum_v[s*SLICE_W +: SLICE_W];
                    st_d.icarry[s]                 = icout_v[s];
                end
                if (dump) begin
                    for (int s = 0; s < N_STAGES; s++) begin
                        st_d.dly[s][base +: SLICE_W] = csrc_v[s*SLICE_W +: SLICE_W];
                        st_d.ccarry[s]               = ccout_v[s];
                    end
                    if (slice_idx != LAST_SLICE) begin
                        st_d.res[base +: SLICE_W] = comb_last;
                    end
                end
            end
            if (emit) begin
                st_d.out_valid = 1'b1;
                st_d.out_data  = scaled;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
endmodule

// File: rtl/cic_sliced_decim_chk.sv
module cic_sliced_decim_chk #(
    parameter int OUT_W   = 24,
    parameter int CODE_W  = 3,
    parameter int CNT_W   = 9,
    parameter int MIN_LOG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_error,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_data,
    input logic [CODE_W-1:0] rate_eff,
    input logic [CODE_W-1:0] rate_code,
    input logic [CNT_W-1:0]  dec_cnt
);
    // R5: output strobe never lasts two cycles
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7: error flag only follows an offered input
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_error |-> $past(in_valid));

    // R9: data holds between strobes
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R8: a ratio change produces no output in the following cycle
    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_eff != rate_code) |=> !out_valid);

    // R2: ratio counter stays below the selected ratio
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(dec_cnt) < (32'(1) << (MIN_LOG + 32'(rate_code))));
endmodule

bind cic_sliced_decim cic_sliced_decim_chk #(
    .OUT_W   (OUT_W),
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W),
    .MIN_LOG (MIN_LOG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_error  (in_error),
    .out_valid (out_valid),
    .out_data  (out_data),
    .rate_eff  (rate_eff),
    .rate_code (rate_code),
    .dec_cnt   (dec_cnt)
);

// File: tb/tb_cic_sliced_decim.sv
module tb_cic_sliced_decim;
    localparam int NS     = 8;
    localparam int WORD_W = 112;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_data = '0;
    logic [2:0]  rate_sel = '0;
    logic        out_valid;
    logic [23:0] out_data;
    logic        in_error;

    cic_sliced_decim dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .in_error  (in_error)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc++;

    // Reference model: full-width arithmetic
    logic signed [WORD_W-1:0] m_int [NS];
    logic signed [WORD_W-1:0] m_dly [NS];
    int          m_cnt;
    int          m_code;
    logic [23:0] exp_q [$];
    int          exp_cyc [$];
    int          n_out = 0;
    int          err_seen = 0;
    logic [23:0] last_out = '0;
    logic [31:0] lfsr = 32'h1234_5679;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset(input int code);
        for (int s = 0; s < NS; s++) begin
            m_int[s] = '0;
            m_dly[s] = '0;
        end
        m_cnt  = 0;
        m_code = (code > 5) ? 5 : code;
        exp_q.delete();
        exp_cyc.delete();
    endfunction

    function automatic void model_step(input logic [17:0] x);
        logic signed [WORD_W-1:0] v;
        logic signed [WORD_W-1:0] c;
        logic signed [WORD_W-1:0] t;
        logic signed [WORD_W-1:0] r;
        int ratio;
        int sh;
        v = {{(WORD_W-18){x[17]}}, x};
        for (int s = 0; s < NS; s++) begin
            m_int[s] = m_int[s] + v;
            v = m_int[s];
        end
        ratio = 16 << m_code;
        if (m_cnt == ratio - 1) begin
            c = v;
            for (int s = 0; s < NS; s++) begin
                t = c - m_dly[s];
                m_dly[s] = c;
                c = t;
            end
            sh = 8 * (4 + m_code) + 18 - 24;
            r = c >>> sh;
            exp_q.push_back(r[23:0]);
            exp_cyc.push_back(cyc + 9);
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
    endfunction

    // Output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                n_out++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected output", longint'(out_data), 0);
                end else begin
                    logic [23:0] e;
                    int ec;
                    e  = exp_q.pop_front();
                    ec = exp_cyc.pop_front();
                    chk(out_data == e, "R3 output value", longint'(out_data), longint'(e));
                    chk(cyc == ec, "R5 output cycle", cyc, ec);
                end
                last_out = out_data;
            end
            if (in_error) err_seen++;
        end
    end

    function automatic logic [17:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[17:0];
    endfunction

    task automatic send(input logic [17:0] x, input int space);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        model_step(x);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (space - 2) @(negedge clk);
    endtask

    task automatic set_rate(input int code, input bit with_input);
        @(negedge clk);
        rate_sel = 3'(code);
        in_valid = with_input;
        in_data  = 18'h15A5A;
        model_reset(code);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all outputs produced", exp_q.size(), 0);
    endtask

    task automatic run(input int code, input int n_samples, input int mode);
        int before_out;
        int before_err;
        before_out = n_out;
        before_err = err_seen;
        for (int i = 0; i < n_samples; i++) begin
            logic [17:0] x;
            case (mode)
                0:       x = (i % 2 == 0) ? 18'h1FFFF : 18'h20000;
                1:       x = 18'(i * 997);
                default: x = next_rand();
            endcase
            send(x, 8 + (i % 2));
        end
        drain();
        chk(n_out - before_out == n_samples / (16 << ((code > 5) ? 5 : code)),
            "R2 output count", n_out - before_out, n_samples / (16 << ((code > 5) ? 5 : code)));
        chk(err_seen == before_err, "R6 back-to-back inputs accepted", err_seen, before_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_error == 1'b0, "R1 in_error", in_error, 0);
        chk(out_data == '0, "R1 out_data", out_data, 0);
        rst_n = 1'b1;
        model_reset(0);
        repeat (2) @(negedge clk);

        // R2/R3: every ratio with several input patterns
        run(0, 48, 0);
        for (int code = 1; code <= 5; code++) begin
            set_rate(code, 1'b0);
            run(code, 3 * (16 << code), code % 3);
        end

        // R8: change ratio while a non-output sample is in flight, with an input offered then
        begin
            int before_out;
            before_out = n_out;
            send(18'h0ABCD, 4);
            set_rate(0, 1'b1);
            repeat (10) @(negedge clk);
            chk(n_out == before_out, "R8 no output from flushed sample", n_out, before_out);
            run(0, 32, 2);
        end

        // R7: intruding input mid-sample is dropped and flagged
        begin
            int before_err;
            before_err = err_seen;
            for (int i = 0; i < 16; i++) begin
                if (i == 5) begin
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_data  = 18'h0F0F0;
                    model_step(18'h0F0F0);
                    @(negedge clk);
                    in_valid = 1'b0;
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_data  = 18'h1FFFF;
                    @(negedge clk);
                    in_valid = 1'b0;
                    repeat (4) @(negedge clk);
                end else begin
                    send(next_rand(), 8);
                end
            end
            drain();
            chk(err_seen - before_err == 1, "R7 single error pulse", err_seen - before_err, 1);
        end

        // R4: full-scale DC gain
        for (int i = 0; i < 160; i++) send(18'h1FFFF, 8);
        drain();
        chk(last_out == 24'h7FFFC0, "R4 positive full scale", longint'(last_out), 24'h7FFFC0);
        for (int i = 0; i < 160; i++) send(18'h20000, 8);
        drain();
        chk(last_out == 24'h800000, "R4 negative full scale", longint'(last_out), 24'h800000);

        // R9: data holds while non-output samples go through
        begin
            logic [23:0] held;
            held = out_data;
            for (int i = 0; i < 5; i++) begin
                send(next_rand(), 8);
                chk(out_data == held, "R9 out_data held", longint'(out_data), longint'(held));
            end
            for (int i = 0; i < 11; i++) send(next_rand(), 8);
            drain();
        end

        // R2: code 7 behaves as 512
        set_rate(7, 1'b0);
        run(7, 512, 2);

        chk(exp_q.size() == 0, "R2 no pending outputs", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule